// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block decides how a small processor core comes out of reset. While the core's reset input is high, instruction fetch stays blocked. During that time the block also watches the debug port. If the debugger writes the main stack pointer, it sets a tracking flag for that register. If the debugger writes the program counter, it sets a separate flag. A program counter write counts whether it comes directly or as the start address of a loaded program image.

When reset drops, the block first loads the vector table base with a fixed value. It then reads the initial stack pointer from the base address and the initial program counter from the base address plus four, in that order. Each read uses a valid/ready request channel and waits for a one-cycle read-data-valid response before the next step. A read is skipped when its register carries a debugger value from the reset window, so that value survives. Fetching is enabled one cycle after the sequence has finished. If reset rises again before the sequence is complete, the sequence is dropped and the block waits in the held state.

Top module: `rst_vec_seq`

## Requirements
- R1: `fetch_enable` is low in every cycle after a cycle in which `core_reset` was sampled high.
- R2: After reset is released, `vtor_q` equals the parameter `VTOR_RESET` before the first read request is issued. It stays at that value for as long as requests are issued.
- R3: With no flag set, exactly two reads are issued. The first goes to address `vtor_q`. The second goes to `vtor_q + 4`, and it is only issued after the response to the first has arrived. `pc_q` takes the second read's data.
- R4: A debug write is tracked while `core_reset` is high. `dbg_reg_sel` = 0 selects the stack pointer and 1 selects the program counter. A pulse on `dbg_img_we` also counts as a program counter write, and it loads `dbg_img_entry`. If it coincides with a direct write, the image value wins.
- R5: If the program counter flag is set at release, no read to `vtor_q + 4` is issued and `pc_q` keeps the debugger value.
- R6: If the stack pointer flag is set at release, no read to `vtor_q` is issued and `sp_q` keeps the debugger value unchanged.
- R7: `fetch_enable` rises two cycles after the cycle in which the last needed response is presented. If both reads are skipped, it rises three cycles after the cycle in which reset is first sampled low. `fetch_enable` is never high in a cycle that follows a cycle with a pending read request.
- R8: Both flags are cleared on every rising edge of `core_reset`, so writes from an earlier reset window cause no read to be skipped.
- R9: A debug write made while `core_reset` is low updates `sp_q` or `pc_q` on the next clock edge.
- R10: A stack pointer taken from memory has its two low bits forced to zero.
- R11: If `core_reset` rises during the read sequence, `mem_req_valid` is low from the next cycle on. After the next release, the sequence restarts from the beginning.
- R12: While `mem_req_valid` is high, `mem_req_ready` is low and reset is not asserted, the request stays valid with an unchanged address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset of the sequencer |
| core_reset | input | 1 | Core reset request, high holds the core |
| dbg_reg_we | input | 1 | Debug register write strobe |
| dbg_reg_sel | input | 1 | Debug write target: 0 stack pointer, 1 program counter |
| dbg_reg_wdata | input | DW | Debug write data |
| dbg_img_we | input | 1 | Image load carrying a start address |
| dbg_img_entry | input | DW | Start address from the loaded image |
| mem_req_valid | output | 1 | Vector read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | DW | Vector read address |
| mem_rsp_valid | input | 1 | Read data valid, one cycle |
| mem_rsp_data | input | DW | Read data |
| vtor_q | output | DW | Vector table base |
| sp_q | output | DW | Main stack pointer |
| pc_q | output | DW | Program counter |
| fetch_enable | output | 1 | Instruction fetch allowed |

## Verification
The checker watches four properties in every cycle:
- fetch stays blocked after reset is seen and while a read is pending;
- every request targets the base or base plus four, with the base already loaded;
- a stalled request keeps its address;
- an abandoned sequence drops its request.

Other behaviour can only be shown by the bench's scenarios, which compare against a memory model:
- which reads are skipped for each flag combination;
- that debugger values survive release;
- that flags clear on a new reset window;
- the stack pointer masking;
- the exact cycle in which fetch is enabled under random ready and latency.

// File: rtl/rst_vec_seq.sv
module rst_vec_seq #(
  parameter int DW = 32,
  parameter logic [DW-1:0] VTOR_RESET = '0,
  parameter int SP_ALIGN = 2,
  parameter int PC_SLOT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_reset,
  input  logic          dbg_reg_we,
  input  logic          dbg_reg_sel,
  input  logic [DW-1:0] dbg_reg_wdata,
  input  logic          dbg_img_we,
  input  logic [DW-1:0] dbg_img_entry,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [DW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic [DW-1:0] vtor_q,
  output logic [DW-1:0] sp_q,
  output logic [DW-1:0] pc_q,
  output logic          fetch_enable
);
  localparam logic [DW-1:0] SP_MASK = ~((DW'(1) << SP_ALIGN) - DW'(1));
  localparam logic [DW-1:0] PC_OFS = DW'(PC_SLOT);

  typedef enum logic [2:0] {
    S_HOLD, S_BASE, S_SPREQ, S_SPWAIT, S_PCREQ, S_PCWAIT, S_DONE, S_RUN
  } st_t;

  st_t st, st_nx;
  logic rst_d, sp_mark, pc_mark;

  wire sp_dbg = dbg_reg_we && !dbg_reg_sel;
  wire pc_dbg = dbg_img_we || (dbg_reg_we && dbg_reg_sel);
  wire [DW-1:0] pc_dbg_val = dbg_img_we ? dbg_img_entry : dbg_reg_wdata;
  wire sp_load = (st == S_SPWAIT) && mem_rsp_valid && !core_reset;
  wire pc_load = (st == S_PCWAIT) && mem_rsp_valid && !core_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_d   <= 1'b0;
      sp_mark <= 1'b0;
      pc_mark <= 1'b0;
    end else begin
      rst_d <= core_reset;
      if (core_reset) begin
        sp_mark <= (sp_mark && rst_d) || sp_dbg;
        pc_mark <= (pc_mark && rst_d) || pc_dbg;
      end
    end
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      S_HOLD:   st_nx = S_BASE;
      S_BASE:   st_nx = sp_mark ? (pc_mark ? S_DONE : S_PCREQ) : S_SPREQ;
      S_SPREQ:  if (mem_req_ready) st_nx = S_SPWAIT;
      S_SPWAIT: if (mem_rsp_valid) st_nx = pc_mark ? S_DONE : S_PCREQ;
      S_PCREQ:  if (mem_req_ready) st_nx = S_PCWAIT;
      S_PCWAIT: if (mem_rsp_valid) st_nx = S_DONE;
      S_DONE:   st_nx = S_RUN;
      default:  st_nx = S_RUN;
    endcase
    if (core_reset) st_nx = S_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_HOLD;
      vtor_q <= '0;
      sp_q   <= '0;
      pc_q   <= '0;
    end else begin
      st <= st_nx;
      if (st == S_HOLD && !core_reset) vtor_q <= VTOR_RESET;
      if (sp_dbg) sp_q <= dbg_reg_wdata;
      else if (sp_load) sp_q <= mem_rsp_data & SP_MASK;
      if (pc_dbg) pc_q <= pc_dbg_val;
      else if (pc_load) pc_q <= mem_rsp_data;
    end
  end

  assign mem_req_valid = (st == S_SPREQ) || (st == S_PCREQ);
  assign mem_req_addr  = (st == S_PCREQ) ? vtor_q + PC_OFS : vtor_q;
  assign fetch_enable  = (st == S_RUN);
endmodule

// File: rtl/rst_vec_seq_chk.sv
module rst_vec_seq_chk #(
  parameter int DW = 32,
  parameter logic [DW-1:0] VTOR_RESET = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_reset,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [DW-1:0] mem_req_addr,
  input logic [DW-1:0] vtor_q,
  input logic          fetch_enable
);
  // R1
  hold_blocks_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> !fetch_enable);
  // R7
  no_fetch_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !fetch_enable);
  // R2
  base_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> vtor_q == VTOR_RESET);
  // R3
  vec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr == vtor_q || mem_req_addr == vtor_q + DW'(4)));
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !core_reset |=> mem_req_valid && $stable(mem_req_addr));
  // R11
  abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> !mem_req_valid);
endmodule

bind rst_vec_seq rst_vec_seq_chk #(.DW(DW), .VTOR_RESET(VTOR_RESET)) chk (
  .clk(clk), .rst_n(rst_n), .core_reset(core_reset),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .vtor_q(vtor_q), .fetch_enable(fetch_enable)
);

// File: tb/rst_vec_seq_test.sv
`timescale 1ns/1ps
module rst_vec_seq_test;
  localparam logic [31:0] BASE = 32'h2000_0040;

  logic clk = 0, rst_n = 0, core_reset = 1;
  logic dbg_reg_we = 0, dbg_reg_sel = 0, dbg_img_we = 0;
  logic [31:0] dbg_reg_wdata = 0, dbg_img_entry = 0;
  logic mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_req_addr, mem_rsp_data = 0, vtor_q, sp_q, pc_q;
  logic fetch_enable;

  int total = 0, bad = 0, cyc = 0, nreq = 0, last_rsp = 0, lat = 0;
  bit pend = 0;
  logic [31:0] paddr, salt = 0;
  logic [31:0] log_a [4];

  rst_vec_seq #(.DW(32), .VTOR_RESET(BASE)) uut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return ((a ^ salt) * 32'h9E37_79B1) | 32'h3;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(posedge clk) begin
    #2;
    mem_rsp_valid = 0;
    if (core_reset) pend = 0;
    else if (pend) begin
      if (lat == 0) begin
        mem_rsp_valid = 1; mem_rsp_data = mem_word(paddr); pend = 0; last_rsp = cyc;
      end else lat--;
    end
    mem_req_ready = ($urandom % 3) != 0;
    if (mem_req_valid && mem_req_ready && !core_reset) begin
      if (nreq < 4) log_a[nreq] = mem_req_addr;
      nreq++;
      chk(vtor_q == BASE, "R2", "base at request", vtor_q, BASE);
      paddr = mem_req_addr; pend = 1; lat = $urandom % 3;
    end
  end

  task automatic hold_and_write(bit wsp, bit wpc, bit img, logic [31:0] spv, logic [31:0] pcv);
    @(negedge clk) core_reset = 1;
    repeat (1 + $urandom % 3) @(negedge clk);
    chk(fetch_enable == 0, "R1", "fetch while held", 32'(fetch_enable), 0);
    if (wsp) begin
      dbg_reg_we = 1; dbg_reg_sel = 0; dbg_reg_wdata = spv;
      @(negedge clk) dbg_reg_we = 0;
    end
    if (wpc) begin
      if (img) begin
        dbg_img_we = 1; dbg_img_entry = pcv;
        dbg_reg_we = 1; dbg_reg_sel = 1; dbg_reg_wdata = ~pcv;
      end else begin
        dbg_reg_we = 1; dbg_reg_sel = 1; dbg_reg_wdata = pcv;
      end
      @(negedge clk) begin dbg_reg_we = 0; dbg_img_we = 0; end
    end
  endtask

  task automatic release_and_check(bit wsp, bit wpc, bit img, logic [31:0] spv, logic [31:0] pcv);
    int rel, fe_cyc, nexp, fe_exp;
    bit seen = 0;
    nreq = 0; rel = cyc; core_reset = 0; fe_cyc = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (fetch_enable) begin seen = 1; fe_cyc = cyc; end
    end
    nexp = (wsp ? 0 : 1) + (wpc ? 0 : 1);
    chk(seen, "R7", "fetch enabled", 32'(seen), 1);
    chk(nreq == nexp, wpc ? "R5" : (wsp ? "R6" : "R3"), "read count", nreq, nexp);
    if (nexp >= 1 && nreq >= 1)
      chk(log_a[0] == (wsp ? BASE + 4 : BASE), "R3", "first addr", log_a[0], wsp ? BASE + 4 : BASE);
    if (nexp == 2 && nreq >= 2)
      chk(log_a[1] == BASE + 4, "R3", "second addr", log_a[1], BASE + 4);
    fe_exp = (nexp == 0) ? rel + 3 : last_rsp + 2;
    chk(fe_cyc == fe_exp, "R7", "fetch cycle", fe_cyc, fe_exp);
    chk(vtor_q == BASE, "R2", "base", vtor_q, BASE);
    if (wsp) chk(sp_q == spv, "R6", "kept sp", sp_q, spv);
    else chk(sp_q == (mem_word(BASE) & ~32'h3), "R10", "fetched sp", sp_q, mem_word(BASE) & ~32'h3);
    if (wpc) chk(pc_q == pcv, img ? "R4" : "R5", "kept pc", pc_q, pcv);
    else chk(pc_q == mem_word(BASE + 4), "R3", "fetched pc", pc_q, mem_word(BASE + 4));
  endtask

  task automatic run_seq(bit wsp, bit wpc, bit img);
    logic [31:0] spv = $urandom, pcv = $urandom;
    salt = $urandom;
    hold_and_write(wsp, wpc, img, spv, pcv);
    release_and_check(wsp, wpc, img, spv, pcv);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(fetch_enable == 0, "R1", "reset fetch", 32'(fetch_enable), 0);
    chk(mem_req_valid == 0, "R3", "reset req", 32'(mem_req_valid), 0);
    chk(vtor_q == 0, "R2", "reset base", vtor_q, 0);
    rst_n = 1;
    run_seq(0, 0, 0);
    run_seq(1, 1, 0);
    run_seq(0, 1, 1);
    run_seq(1, 0, 0);
    // R8: earlier window's pc write must not skip a read
    run_seq(0, 1, 0);
    run_seq(0, 0, 0);
    // R9: writes while running
    @(negedge clk) begin dbg_reg_we = 1; dbg_reg_sel = 1; dbg_reg_wdata = 32'hCAFE_0001; end
    @(negedge clk) begin dbg_reg_sel = 0; dbg_reg_wdata = 32'h0000_1237; end
    chk(pc_q == 32'hCAFE_0001, "R9", "running pc write", pc_q, 32'hCAFE_0001);
    @(negedge clk) dbg_reg_we = 0;
    chk(sp_q == 32'h0000_1237, "R9", "running sp write", sp_q, 32'h0000_1237);
    // R11: abandon during the sequence
    @(negedge clk) core_reset = 1;
    repeat (2) @(negedge clk);
    nreq = 0; core_reset = 0;
    for (int i = 0; i < 50 && nreq == 0; i++) @(negedge clk);
    core_reset = 1;
    @(negedge clk);
    chk(mem_req_valid == 0, "R11", "req dropped", 32'(mem_req_valid), 0);
    @(negedge clk);
    chk(fetch_enable == 0, "R11", "no fetch after abandon", 32'(fetch_enable), 0);
    release_and_check(0, 0, 0, 0, 0);
    for (int k = 0; k < 24; k++) begin
      bit a = $urandom % 2, b = $urandom % 2, c = $urandom % 2;
      run_seq(a, b, c);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule